// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This block is a watchdog that counts ticks of a selectable time base and issues a one-cycle reset pulse when software fails to restart it in time. The time base is either a slow tick strobe from a sub-oscillator domain, already brought onto the system clock, or the system clock divided by four. Ticks pass through a fixed binary pre-divider and then a prescaler. A configuration input picks one of four prescaler taps, and a last divide-by-two stage after that tap sets the time-out.

A key register must hold one exact pattern to stop the watchdog. Any other value leaves it running. The key resets to that stopping pattern, so the watchdog is idle after power-up until software writes a different key. Software restarts the count with clear strobes. Configuration decides whether one strobe is enough or whether two different strobes must both arrive. A master enable input turns the whole function off.

Top module: `wdt_keyed`

## Requirements
- R1: With cfg_src_sel_i = 0, every system clock cycle in which sub_tick_i is high counts as one tick. With cfg_src_sel_i = 1, sub_tick_i is ignored and one tick occurs every fourth system clock cycle. That divide-by-four phase restarts whenever the count restarts.
- R2: With a DIV_W-bit pre-divider and a PRE_W-bit prescaler, tap select s (cfg_tap_sel_i, 0 to 3) gives a time-out after 2^(DIV_W+PRE_W-2+s) ticks counted from the restart. The defaults (8, 7) give 2^13, 2^14, 2^15 and 2^16 ticks.
- R3: wdt_rst_o is low after reset. It goes high for exactly one cycle after the clock edge on which the final tick of the period lands. The count then restarts from zero, so pulses repeat once per period.
- R4: The key register loads key_d_i on a clock edge with key_we_i high. It resets to 4'b1010. While it holds 4'b1010, the chain is held at zero and no pulse occurs. Any other value lets the watchdog count.
- R5: When the key changes from 4'b1010 to another value, counting starts from zero at that edge, whatever count existed before the watchdog was stopped.
- R6: While cfg_en_i is low, no pulse occurs and clr1_i and clr2_i leave no trace. A strobe given while the master enable is off is not remembered after enabling. The same applies while the key is 4'b1010.
- R7: With cfg_two_clr_i = 0, a strobe on either clr1_i or clr2_i restarts the count from zero at that edge.
- R8: With cfg_two_clr_i = 1, a restart needs both a clr1_i strobe and a clr2_i strobe. They may arrive in either order, apart or on the same edge. Repeating one strobe does not complete the pair. After a pair restarts the count, a fresh pair is needed.
- R9: A restart by clear on the same edge as the final tick of the period wins. No pulse is issued, and the next period starts from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | Master enable of the watchdog function |
| cfg_src_sel_i | input | 1 | Time base: 0 sub-oscillator tick, 1 system clock / 4 |
| cfg_tap_sel_i | input | 2 | Prescaler tap select (time-out length) |
| cfg_two_clr_i | input | 1 | 0: single-strobe clear, 1: paired clear |
| sub_tick_i | input | 1 | Tick strobe from the sub-oscillator domain |
| key_we_i | input | 1 | Key register write strobe |
| key_d_i | input | KEY_W | Key register write data |
| clr1_i | input | 1 | First clear strobe |
| clr2_i | input | 1 | Second clear strobe |
| wdt_rst_o | output | 1 | One-cycle time-out reset pulse |

## Verification
The bench measures the exact edge of each time-out for every tap and both time bases, including a half-rate sub tick. An off-by-one tap, a wrong pre-divider width or a free-running divide-by-four phase would move that edge. In paired mode it sends the same strobe twice, sends the pair in reverse order and on one edge, and sends a single strobe after a completed pair. A design that counted repeats, kept flags after a pair or needed a fixed order would restart the count at the wrong time. It also stops the watchdog by key in mid-count and restarts it, clears on the very edge of the time-out, and sends a strobe while the master enable is off. A design that resumed an old count, let a pulse slip through a clear, or remembered a flag across the enable would shift the next pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // time base selection
   typedef enum logic {
      SRC_SUB  = 1'b0,
      SRC_SYS4 = 1'b1
   } src_e;

   // number of selectable prescaler taps
   localparam int unsigned TAP_COUNT = 4;
   localparam int unsigned TAP_SEL_W = $clog2(TAP_COUNT);
   // divide ratio of the system clock time base
   localparam int unsigned SYS_DIV_W = 2;
endpackage

// File: rtl/wdt_tick_src.sv
module wdt_tick_src
   import wdt_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic restart_i,
   input  logic sel_i,
   input  logic sub_tick_i,
   output logic tick_o
);
   logic [SYS_DIV_W-1:0] ph_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ph_q <= '0;
      else if (restart_i) ph_q <= '0;
      else                ph_q <= ph_q + 1'b1;
   end

   always_comb begin
      unique case (src_e'(sel_i))
         SRC_SYS4: tick_o = en_i && (&ph_q);
         default:  tick_o = en_i && sub_tick_i;
      endcase
   end

   // R1: the divided system clock never ticks on two cycles in a row
   a_r1_sys_div_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && tick_o && !restart_i) |=> !tick_o);
endmodule

// File: rtl/wdt_cnt_stage.sv
module wdt_cnt_stage #(
   parameter int unsigned W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] q_o,
   output logic         co_o
);
   if (W < 1) begin : g_bad_w
      $error("wdt_cnt_stage: W must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o <= '0;
      else if (clr_i) q_o <= '0;
      else if (inc_i) q_o <= q_o + 1'b1;
   end

   assign co_o = inc_i && (&q_o);

   // R3: a restart leaves the stage at zero on the next cycle
   a_r3_stage_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (q_o == '0));
endmodule

// File: rtl/wdt_clr_ctl.sv
module wdt_clr_ctl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic two_i,
   input  logic clr1_i,
   input  logic clr2_i,
   output logic fire_o
);
   logic f1_q, f2_q;
   logic have1, have2;

   assign have1 = f1_q || clr1_i;
   assign have2 = f2_q || clr2_i;

   always_comb begin
      if (!en_i)      fire_o = 1'b0;
      else if (two_i) fire_o = have1 && have2;
      else            fire_o = clr1_i || clr2_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         f1_q <= 1'b0;
         f2_q <= 1'b0;
      end else if (!en_i || !two_i || fire_o) begin
         f1_q <= 1'b0;
         f2_q <= 1'b0;
      end else begin
         f1_q <= have1;
         f2_q <= have2;
      end
   end

   // R8: a completed pair leaves no flag behind
   a_r8_pair_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_o |=> (!f1_q && !f2_q));
   // R6: nothing is remembered while the function is off
   a_r6_no_flags_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!f1_q && !f2_q));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_pkg::*;
#(
   parameter int unsigned     DIV_W   = 8,
   parameter int unsigned     PRE_W   = 7,
   parameter int unsigned     KEY_W   = 4,
   parameter logic [KEY_W-1:0] KEY_OFF = KEY_W'(4'b1010)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 cfg_en_i,
   input  logic                 cfg_src_sel_i,
   input  logic [1:0]           cfg_tap_sel_i,
   input  logic                 cfg_two_clr_i,
   input  logic                 sub_tick_i,
   input  logic                 key_we_i,
   input  logic [KEY_W-1:0]     key_d_i,
   input  logic                 clr1_i,
   input  logic                 clr2_i,
   output logic                 wdt_rst_o
);
   localparam int unsigned TAP_LO = PRE_W - TAP_COUNT;

   if (PRE_W < TAP_COUNT || DIV_W < 1 || TAP_SEL_W != 2) begin : g_bad_cfg
      $error("wdt_keyed: PRE_W must cover all taps and DIV_W must be at least 1");
   end

   logic [KEY_W-1:0]   key_q;
   logic               run, fire, tick, tmo, restart;
   logic [DIV_W-1:0]   div_q;
   logic [PRE_W-1:0]   pre_q;
   logic               div_co, pre_co, sel_co;
   logic [TAP_COUNT-1:0] tap_co;
   logic               fin_q, rst_q;

   // key register, resets to the stopping pattern
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       key_q <= KEY_OFF;
      else if (key_we_i) key_q <= key_d_i;
   end

   assign run     = cfg_en_i && (key_q != KEY_OFF);
   assign restart = !run || fire || tmo;

   wdt_clr_ctl i_clr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (run),
      .two_i  (cfg_two_clr_i),
      .clr1_i (clr1_i),
      .clr2_i (clr2_i),
      .fire_o (fire)
   );

   wdt_tick_src i_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (run),
      .restart_i  (restart),
      .sel_i      (cfg_src_sel_i),
      .sub_tick_i (sub_tick_i),
      .tick_o     (tick)
   );

   wdt_cnt_stage #(.W(DIV_W)) i_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (restart),
      .inc_i  (tick),
      .q_o    (div_q),
      .co_o   (div_co)
   );

   wdt_cnt_stage #(.W(PRE_W)) i_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (restart),
      .inc_i  (div_co),
      .q_o    (pre_q),
      .co_o   (pre_co)
   );

   // carry out of each selectable prescaler tap
   for (genvar s = 0; s < TAP_COUNT; s++) begin : g_tap
      if (s == TAP_COUNT - 1) begin : g_top
         assign tap_co[s] = pre_co;
      end else begin : g_mid
         assign tap_co[s] = div_co && (&pre_q[TAP_LO+s:0]);
      end
   end

   assign sel_co = tap_co[cfg_tap_sel_i];
   assign tmo    = sel_co && fin_q && !fire;

   // final divide-by-two stage
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      fin_q <= 1'b0;
      else if (restart) fin_q <= 1'b0;
      else if (sel_co)  fin_q <= !fin_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rst_q <= 1'b0;
      else         rst_q <= tmo;
   end

   assign wdt_rst_o = rst_q;

   // R3: the time-out pulse lasts one cycle
   a_r3_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdt_rst_o |=> !wdt_rst_o);
   // R6: master enable off forbids a pulse
   a_r6_master_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_en_i |=> !wdt_rst_o);
   // R4: a held stopping key forbids a pulse
   a_r4_key_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (key_q == KEY_OFF) |=> !wdt_rst_o);
   // R9: a clear on the final edge suppresses the pulse
   a_r9_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire |=> !wdt_rst_o);
endmodule

// File: tb/test_wdt_keyed.sv
module test_wdt_keyed;
   localparam int DIV_W = 2;
   localparam int PRE_W = 4;
   localparam int NV    = 7;
   // base period in ticks for tap 0 is 2^(DIV_W+PRE_W-2) = 16
   localparam int VSRC  [NV] = '{0, 0, 0, 0, 1, 1, 0};
   localparam int VSEL  [NV] = '{0, 1, 2, 3, 0, 1, 0};
   localparam int VHALF [NV] = '{0, 0, 0, 0, 0, 0, 1};
   localparam int VP1   [NV] = '{16, 32, 64, 128, 64, 128, 31};
   localparam int VP2   [NV] = '{15, 31, 63, 127, 63, 127, 31};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_en = 1'b1, cfg_src = 1'b0, cfg_two = 1'b0;
   logic [1:0] cfg_tap = 2'd0;
   logic       sub_tick = 1'b0, key_we = 1'b0, clr1 = 1'b0, clr2 = 1'b0;
   logic [3:0] key_d = 4'd0;
   logic       wdt_rst;

   int tests = 0, fails = 0, cycles = 0;
   logic half_mode = 1'b0, ph = 1'b0;

   always #2 clk = ~clk;

   wdt_keyed #(.DIV_W(DIV_W), .PRE_W(PRE_W)) i_wdt_keyed (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .cfg_en_i      (cfg_en),
      .cfg_src_sel_i (cfg_src),
      .cfg_tap_sel_i (cfg_tap),
      .cfg_two_clr_i (cfg_two),
      .sub_tick_i    (sub_tick),
      .key_we_i      (key_we),
      .key_d_i       (key_d),
      .clr1_i        (clr1),
      .clr2_i        (clr2),
      .wdt_rst_o     (wdt_rst)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         tests++;
         fails++;
         $display("FAIL watchdog (all requirements): got %0d cycles expected fewer", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input int act, input int exp, input string req);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // one clock edge with the given strobes; returns the output after it
   task automatic cyc(input logic c1, input logic c2, input logic we,
                      input logic [3:0] kd, output logic p);
      clr1 = c1; clr2 = c2; key_we = we; key_d = kd;
      sub_tick = half_mode ? ph : 1'b1;
      ph = ~ph;
      @(posedge clk);
      #1;
      clr1 = 1'b0; clr2 = 1'b0; key_we = 1'b0;
      p = wdt_rst;
   endtask

   task automatic wait_pulse(input int limit, output int n);
      logic p;
      n = 0;
      for (int k = 1; k <= limit; k++) begin
         cyc(1'b0, 1'b0, 1'b0, 4'd0, p);
         if (p) begin
            n = k;
            break;
         end
      end
   endtask

   // stop by key, then start with key 0 on edge E0
   task automatic arm();
      logic p;
      cyc(1'b0, 1'b0, 1'b1, 4'b1010, p);
      ph = 1'b0;
      cyc(1'b0, 1'b0, 1'b1, 4'b0000, p);
   endtask

   // edges counted from E0; returns the edge of the first pulse or 0
   task automatic run_pattern(input int a1, input int a2, input int b1,
                              input int kw, input logic [3:0] kv,
                              input int kw2, input logic [3:0] kv2,
                              output int first);
      logic p;
      first = 0;
      for (int k = 1; k <= 200; k++) begin
         cyc(k == a1 || k == a2, k == b1, k == kw || k == kw2,
             (k == kw2) ? kv2 : kv, p);
         if (p && first == 0) first = k;
      end
   endtask

   initial begin
      int n, first;
      logic p;
      #1;
      repeat (3) @(posedge clk);
      #1;
      check(int'(wdt_rst), 0, "R3 reset output low");
      rst_n = 1'b1;
      // R4: reset key value stops the watchdog
      wait_pulse(200, n);
      check(n, 0, "R4 reset key holds watchdog off");

      // vector table: R1 time base, R2 tap, R3 one-cycle repeating pulse
      for (int v = 0; v < NV; v++) begin
         cfg_src = VSRC[v][0];
         cfg_tap = VSEL[v][1:0];
         half_mode = VHALF[v][0];
         arm();
         wait_pulse(600, n);
         check(n, VP1[v], $sformatf("R2/R1 first period vector %0d", v));
         cyc(1'b0, 1'b0, 1'b0, 4'd0, p);
         check(int'(p), 0, $sformatf("R3 pulse one cycle vector %0d", v));
         wait_pulse(600, n);
         check(n, VP2[v], $sformatf("R3 repeat period vector %0d", v));
      end
      half_mode = 1'b0;
      cfg_src = 1'b0;
      cfg_tap = 2'd0;

      // R4: key rewritten to the stopping value in mid-count
      arm();
      run_pattern(0, 0, 0, 10, 4'b1010, 0, 4'd0, first);
      check(first, 0, "R4 stopping key written while counting");
      // R5: leaving the stopping key restarts from zero
      arm();
      run_pattern(0, 0, 0, 10, 4'b1010, 12, 4'b0101, first);
      check(first, 28, "R5 restart from zero after key release");

      // R7: single mode
      cfg_two = 1'b0;
      arm();
      run_pattern(10, 0, 0, 0, 4'd0, 0, 4'd0, first);
      check(first, 26, "R7 single clear by clr1");
      arm();
      run_pattern(0, 0, 7, 0, 4'd0, 0, 4'd0, first);
      check(first, 23, "R7 single clear by clr2");
      // R9: clear on the final edge wins
      arm();
      run_pattern(16, 0, 0, 0, 4'd0, 0, 4'd0, first);
      check(first, 32, "R9 clear on time-out edge suppresses pulse");

      // R8: paired mode
      cfg_two = 1'b1;
      arm();
      run_pattern(5, 8, 0, 0, 4'd0, 0, 4'd0, first);
      check(first, 16, "R8 repeated clr1 is not a pair");
      arm();
      run_pattern(0, 0, 9, 0, 4'd0, 0, 4'd0, first);
      check(first, 16, "R8 lone clr2 is not a pair");
      arm();
      run_pattern(5, 12, 10, 0, 4'd0, 0, 4'd0, first);
      check(first, 26, "R8 pair then lone clr1 needs fresh pair");
      arm();
      run_pattern(9, 0, 4, 0, 4'd0, 0, 4'd0, first);
      check(first, 25, "R8 pair in reverse order");
      arm();
      run_pattern(6, 0, 6, 0, 4'd0, 0, 4'd0, first);
      check(first, 22, "R8 pair on one edge");

      // R6: master enable off
      cfg_en = 1'b0;
      arm();
      run_pattern(20, 50, 30, 0, 4'd0, 0, 4'd0, first);
      check(first, 0, "R6 no pulse with master enable off");
      // R6: a strobe while off is forgotten; enable edge counts as a tick
      cyc(1'b1, 1'b0, 1'b0, 4'd0, p);
      cyc(1'b1, 1'b0, 1'b0, 4'd0, p);
      cfg_en = 1'b1;
      cyc(1'b0, 1'b0, 1'b0, 4'd0, p);
      run_pattern(0, 0, 5, 0, 4'd0, 0, 4'd0, first);
      check(first, 15, "R6 clear strobe while off not remembered");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule